// File: doc/BRIEF.md
# Region Protection and Translation Unit

This unit checks and remaps every memory request a processor core issues. The 32-bit address space is split into eight equal 512 MB regions, and the three most significant address bits select one of them. Each region carries a 3-bit physical region number and a 4-bit attribute code. The attribute code sets both the access rights (read, write, execute) and the cache policy that goes with the region. Instruction fetches are looked up in an instruction-side table. Loads and stores are looked up in a data-side table. Each table has its own write port.

A request gives an access type and a virtual address. One clock later the unit returns, with a valid strobe, the physical address, the rights and cache policy of the region, a grant flag and a denial cause. The lookup itself is combinational, and a single register stage follows it. With the `XLATE` parameter cleared, the unit only protects and does not translate. Region numbers written to it are then ignored and the physical address always equals the virtual address. This matches a design that keeps just one attribute field per region.

Top module: `region_guard`

## Requirements
- R1: The region is selected by virtual address bits 31:29. A table write changes only the region named by its region field, and only in the table whose enable is set.
- R2: With `XLATE` set, `rsp_paddr` is the region's 3-bit physical region number in bits 31:29, followed by virtual address bits 28:0 unchanged.
- R3: Attribute codes decode to `rsp_perm` (bit 0 read, bit 1 write, bit 2 execute) and `rsp_cache` (0 bypass, 1 write-through, 2 write-back, 3 isolate) as follows:
  - 0 gives read/write with write-through.
  - 1 gives read/write/execute with write-through.
  - 2 gives read/write/execute with bypass.
  - 3 gives execute only with write-back.
  - 4 gives read/write/execute with write-back.
  - 14 gives read/write with isolate.
- R4: Every other attribute code (5 to 13 and 15) grants no rights and reports cache policy bypass.
- R5: `req_type` 0 is a load and needs read rights. Type 1 is a store and needs write rights. Type 2 is a fetch and needs execute rights. Type 3 is handled as a load.
- R6: `rsp_cause` is 0 when the access is granted. When it is denied, the cause is 1 for a load, 2 for a store and 3 for a fetch. `rsp_ok` is high exactly when the cause is 0.
- R7: After reset every region in both tables maps to itself with attribute code 2, and `rsp_valid` is low.
- R8: Fetches (type 2) use the instruction-side table. All other types use the data-side table.
- R9: A table write takes effect from the next cycle. A request in the same cycle as a write to its region sees the old entry.
- R10: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise.
- R11: With `XLATE` cleared, `rsp_paddr` equals the virtual address of the request, whatever region numbers have been written. Rights and cache policy still follow the written attribute codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 2 | 0 load, 1 store, 2 fetch, 3 handled as load |
| req_vaddr | input | ADDR_W | Virtual address |
| iwr_en | input | 1 | Write enable, instruction-side table |
| iwr_region | input | IDX_W | Region written, instruction side |
| iwr_base | input | IDX_W | New physical region number, instruction side |
| iwr_attr | input | 4 | New attribute code, instruction side |
| dwr_en | input | 1 | Write enable, data-side table |
| dwr_region | input | IDX_W | Region written, data side |
| dwr_base | input | IDX_W | New physical region number, data side |
| dwr_attr | input | 4 | New attribute code, data side |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_perm | output | 3 | Region rights: bit 0 read, bit 1 write, bit 2 execute |
| rsp_cache | output | 2 | 0 bypass, 1 write-through, 2 write-back, 3 isolate |
| rsp_ok | output | 1 | Access granted |
| rsp_cause | output | 2 | 0 none, 1 load, 2 store, 3 fetch prohibited |

## Verification
The assertions assume a few things about the inputs. `req_type` and `req_vaddr` must be driven at known values whenever `req_valid` is high. The two write ports may fire in the same cycle as a request, including a write to the very region being accessed. The bench drives all inputs on the falling edge. It keeps `req_valid` low during reset and only ever drives defined values. It does put a write and a request to the same region in one cycle, so the check that the old entry is seen is exercised.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter bit XLATE  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              iwr_en,
  input  logic [IDX_W-1:0]  iwr_region,
  input  logic [IDX_W-1:0]  iwr_base,
  input  logic [3:0]        iwr_attr,
  input  logic              dwr_en,
  input  logic [IDX_W-1:0]  dwr_region,
  input  logic [IDX_W-1:0]  dwr_base,
  input  logic [3:0]        dwr_attr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [2:0]        rsp_perm,
  output logic [1:0]        rsp_cache,
  output logic              rsp_ok,
  output logic [1:0]        rsp_cause
);
  localparam int NREG = 1 << IDX_W;
  localparam int OFF_W = ADDR_W - IDX_W;
  localparam logic [3:0] RESET_ATTR = 4'd2;

  logic [IDX_W-1:0] ibase [NREG];
  logic [IDX_W-1:0] dbase [NREG];
  logic [3:0]       iattr [NREG];
  logic [3:0]       dattr [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        ibase[r] <= IDX_W'(r);
        dbase[r] <= IDX_W'(r);
        iattr[r] <= RESET_ATTR;
        dattr[r] <= RESET_ATTR;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (iwr_en && iwr_region == IDX_W'(r)) begin
          iattr[r] <= iwr_attr;
          ibase[r] <= XLATE ? iwr_base : IDX_W'(r);
        end
        if (dwr_en && dwr_region == IDX_W'(r)) begin
          dattr[r] <= dwr_attr;
          dbase[r] <= XLATE ? dwr_base : IDX_W'(r);
        end
      end
    end
  end

  wire              is_fetch = (req_type == 2'd2);
  wire [IDX_W-1:0]  idx      = req_vaddr[ADDR_W-1 -: IDX_W];
  wire [IDX_W-1:0]  sel_base = is_fetch ? ibase[idx] : dbase[idx];
  wire [3:0]        sel_attr = is_fetch ? iattr[idx] : dattr[idx];

  logic [2:0] perm;
  logic [1:0] cache;
  always_comb begin
    case (sel_attr)
      4'd0:    begin perm = 3'b011; cache = 2'd1; end
      4'd1:    begin perm = 3'b111; cache = 2'd1; end
      4'd2:    begin perm = 3'b111; cache = 2'd0; end
      4'd3:    begin perm = 3'b100; cache = 2'd2; end
      4'd4:    begin perm = 3'b111; cache = 2'd2; end
      4'd14:   begin perm = 3'b011; cache = 2'd3; end
      default: begin perm = 3'b000; cache = 2'd0; end
    endcase
  end

  logic granted;
  logic [1:0] cause;
  always_comb begin
    case (req_type)
      2'd1:    begin granted = perm[1]; cause = 2'd2; end
      2'd2:    begin granted = perm[2]; cause = 2'd3; end
      default: begin granted = perm[0]; cause = 2'd1; end
    endcase
    if (granted) cause = 2'd0;
  end

  logic [ADDR_W-1:0] xl_paddr;
  if (XLATE) begin : g_xlate
    assign xl_paddr = {sel_base, req_vaddr[OFF_W-1:0]};
  end else begin : g_flat
    assign xl_paddr = req_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_cache <= '0;
      rsp_ok    <= 1'b0;
      rsp_cause <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= xl_paddr;
        rsp_perm  <= perm;
        rsp_cache <= cache;
        rsp_ok    <= granted;
        rsp_cause <= cause;
      end
    end
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter bit XLATE  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_type,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_perm,
  input logic [1:0]        rsp_cache,
  input logic              rsp_ok,
  input logic [1:0]        rsp_cause
);
  localparam int OFF_W = ADDR_W - IDX_W;

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
  assert_cause_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok == (rsp_cause == 2'd0)));
  assert_isolate_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cache == 2'd3) |-> rsp_perm == 3'b011);
  assert_none_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm == 3'b000) |-> rsp_cache == 2'd0);
  assert_store_needs_w_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd1) |=> (!rsp_ok || rsp_perm[1]));
  assert_fetch_needs_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd2) |=> (!rsp_ok || rsp_perm[2]));
  assert_flat_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !XLATE) |=> rsp_paddr == $past(req_vaddr));
endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .XLATE(XLATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
  .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_perm(rsp_perm), .rsp_cache(rsp_cache), .rsp_ok(rsp_ok), .rsp_cause(rsp_cause)
);

// File: tb/test_region_guard.sv
module test_region_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic [31:0] req_vaddr = '0;
  logic        iwr_en = 1'b0, dwr_en = 1'b0;
  logic [2:0]  wr_region = '0, wr_base = '0;
  logic [3:0]  wr_attr = '0;

  logic        rsp_valid, rsp_ok, nx_valid, nx_ok;
  logic [31:0] rsp_paddr, nx_paddr;
  logic [2:0]  rsp_perm, nx_perm;
  logic [1:0]  rsp_cache, rsp_cause, nx_cache, nx_cause;

  region_guard i_region_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type), .req_vaddr(req_vaddr),
    .iwr_en(iwr_en), .iwr_region(wr_region), .iwr_base(wr_base), .iwr_attr(wr_attr),
    .dwr_en(dwr_en), .dwr_region(wr_region), .dwr_base(wr_base), .dwr_attr(wr_attr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .rsp_cache(rsp_cache), .rsp_ok(rsp_ok), .rsp_cause(rsp_cause));

  region_guard #(.XLATE(1'b0)) i_region_guard_flat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type), .req_vaddr(req_vaddr),
    .iwr_en(iwr_en), .iwr_region(wr_region), .iwr_base(wr_base), .iwr_attr(wr_attr),
    .dwr_en(dwr_en), .dwr_region(wr_region), .dwr_base(wr_base), .dwr_attr(wr_attr),
    .rsp_valid(nx_valid), .rsp_paddr(nx_paddr), .rsp_perm(nx_perm),
    .rsp_cache(nx_cache), .rsp_ok(nx_ok), .rsp_cause(nx_cause));

  typedef struct {
    logic [31:0] paddr;
    logic [31:0] vaddr;
    logic [2:0]  perm;
    logic [1:0]  cache;
    logic        ok;
    logic [1:0]  cause;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0] m_ib [8], m_db [8];
  logic [3:0] m_ia [8], m_da [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void decode(input logic [3:0] a, output logic [2:0] p, output logic [1:0] c);
    case (a)
      4'd0:    begin p = 3'b011; c = 2'd1; end
      4'd1:    begin p = 3'b111; c = 2'd1; end
      4'd2:    begin p = 3'b111; c = 2'd0; end
      4'd3:    begin p = 3'b100; c = 2'd2; end
      4'd4:    begin p = 3'b111; c = 2'd2; end
      4'd14:   begin p = 3'b011; c = 2'd3; end
      default: begin p = 3'b000; c = 2'd0; end
    endcase
  endfunction

  task automatic step(input bit wi, input bit wd, input logic [2:0] wreg, input logic [2:0] wbase,
                      input logic [3:0] wattr, input bit rq, input logic [1:0] ty,
                      input logic [31:0] va, input string tag);
    exp_t e;
    logic [2:0] r;
    bit g;
    @(negedge clk);
    iwr_en = wi; dwr_en = wd; wr_region = wreg; wr_base = wbase; wr_attr = wattr;
    req_valid = rq; req_type = ty; req_vaddr = va;
    if (rq) begin
      r = va[31:29];
      if (ty == 2'd2) begin
        decode(m_ia[r], e.perm, e.cache);
        e.paddr = {m_ib[r], va[28:0]};
      end else begin
        decode(m_da[r], e.perm, e.cache);
        e.paddr = {m_db[r], va[28:0]};
      end
      case (ty)
        2'd1:    begin g = e.perm[1]; e.cause = 2'd2; end
        2'd2:    begin g = e.perm[2]; e.cause = 2'd3; end
        default: begin g = e.perm[0]; e.cause = 2'd1; end
      endcase
      e.ok = g;
      if (g) e.cause = 2'd0;
      e.vaddr = va;
      e.tag = tag;
      q.push_back(e);
    end
    if (wi) begin m_ib[wreg] = wbase; m_ia[wreg] = wattr; end
    if (wd) begin m_db[wreg] = wbase; m_da[wreg] = wattr; end
  endtask

  task automatic idle();
    step(0, 0, 3'd0, 3'd0, 4'd0, 0, 2'd0, 32'd0, "");
  endtask

  task automatic access(input logic [1:0] ty, input logic [31:0] va, input string tag);
    step(0, 0, 3'd0, 3'd0, 4'd0, 1, ty, va, tag);
  endtask

  function automatic logic [31:0] addr_of(input int r, input int t);
    return {3'(r), 29'(32'h0123_4567 * (r + 1) + 32'h0010_0011 * t)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk("R10 response without request", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " R2 paddr"}, rsp_paddr, e.paddr);
        chk({e.tag, " R3 perm"}, 32'(rsp_perm), 32'(e.perm));
        chk({e.tag, " R3 cache"}, 32'(rsp_cache), 32'(e.cache));
        chk({e.tag, " R6 ok"}, 32'(rsp_ok), 32'(e.ok));
        chk({e.tag, " R6 cause"}, 32'(rsp_cause), 32'(e.cause));
        chk({e.tag, " R11 flat valid"}, 32'(nx_valid), 32'd1);
        chk({e.tag, " R11 flat paddr"}, nx_paddr, e.vaddr);
        chk({e.tag, " R11 flat perm"}, 32'(nx_perm), 32'(e.perm));
        chk({e.tag, " R11 flat cause"}, 32'(nx_cause), 32'(e.cause));
      end
    end
  end

  localparam logic [3:0] DCODES [8] = '{4'd0, 4'd1, 4'd3, 4'd4, 4'd14, 4'd5, 4'd15, 4'd7};

  initial begin
    for (int r = 0; r < 8; r++) begin
      m_ib[r] = 3'(r); m_db[r] = 3'(r); m_ia[r] = 4'd2; m_da[r] = 4'd2;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R7 rsp_valid low after reset", 32'(rsp_valid), 32'd0);

    for (int r = 0; r < 8; r++)
      for (int t = 0; t < 3; t++)
        access(2'(t), addr_of(r, t), "R7 R1 reset identity map");

    for (int r = 0; r < 8; r++)
      step(0, 1, 3'(r), 3'(7 - r), DCODES[r], 0, 2'd0, 32'd0, "");
    for (int r = 0; r < 8; r++)
      for (int t = 0; t < 4; t++)
        access(2'(t), addr_of(r, t + 1), "R1 R5 R8 data table remapped");

    for (int c = 0; c < 16; c++) begin
      step(1, 1, 3'd5, 3'(c), 4'(c), 0, 2'd0, 32'd0, "");
      idle();
      access(2'd0, addr_of(5, c), "R3 R4 sweep load");
      access(2'd1, addr_of(5, c + 1), "R3 R4 sweep store");
      access(2'd2, addr_of(5, c + 2), "R3 R4 sweep fetch");
      access(2'd3, addr_of(5, c + 3), "R5 R6 sweep type3");
    end

    step(0, 1, 3'd2, 3'd3, 4'd15, 1, 2'd0, addr_of(2, 9), "R9 same-cycle old entry");
    access(2'd0, addr_of(2, 10), "R9 new entry next cycle");
    step(1, 0, 3'd6, 3'd1, 4'd3, 0, 2'd0, 32'd0, "");
    access(2'd0, addr_of(6, 3), "R8 data side untouched by instr write");
    access(2'd2, addr_of(6, 4), "R8 fetch uses instr write");
    access(2'd1, addr_of(6, 5), "R8 store uses data side");
    access(2'd2, addr_of(0, 5), "R1 other instr region untouched");

    repeat (4) idle();
    @(negedge clk);
    chk("R10 every request answered", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule